// File: doc/BRIEF.md
# Condition-Bit Predicate Mask Builder

This block assembles two 64-bit predicate masks, one for the source side and one for the destination side of a vector loop. Each bit comes from a single condition bit stored in a condition-register file. A start handshake delivers a 3-bit condition code for each side and a vector length. The block then steps through element indices 0 to VL-1. For each element it asks the register file for one 4-bit field through a one-hot read enable. It takes the returned field one clock later, selects the bit named by the condition code, inverts it if the code asks for that, and stores the result at the element's position in the mask.

Both masks share one read port. The source mask is filled completely before the destination mask. When both are done, the block raises a done-valid signal. The masks stay stable on the outputs until the consumer takes them with done-ready. The parameter `FIELD_OFS` sets which fields the elements use: element i reads field `CR_FIELDS-1-(i+FIELD_OFS)`. An element whose field index would fall below zero reads nothing and gets a cleared mask bit.

Top module: `crpred_mask_builder`

## Requirements
- R1: A condition code c selects field bit c[2:1], and the bit is inverted when c[0] is 0. So 0=LT picks bit 0 inverted, 1=GE bit 0 plain, 2=GT bit 1 inverted, 3=LE bit 1 plain, 4=EQ bit 2 inverted, 5=NE bit 2 plain, 6=SO bit 3 inverted, 7=NS bit 3 plain.
- R2: For each element i below VL, mask bit i equals the selected bit of the field returned for element i, XOR the invert flag.
- R3: The read request for element i is a one-hot `cr_ren`, with its single 1 at bit position CR_FIELDS-1-(i+FIELD_OFS). At most one bit of `cr_ren` is high in any cycle.
- R4: Field data is taken in the cycle after the request. Each element therefore costs exactly two cycles, and `done_valid` rises exactly 4*VL clock edges after the accepting edge.
- R5: All source reads, for elements 0 to VL-1 in rising order, come before any destination read. The destination reads then follow in the same element order.
- R6: In both masks, every bit at position VL or above is 0 when `done_valid` is high.
- R7: With VL=0 the block issues no read, both masks are all zero, and `done_valid` is high right after the accepting edge.
- R8: `start_ready` is high only in the idle state. A start request made while results are pending is not taken, even in the cycle in which `done_ready` releases them.
- R9: `done_valid` stays high, and both masks hold their values, until `done_ready` is seen. After that edge the block is idle.
- R10: An element with i+FIELD_OFS > CR_FIELDS-1 issues no read (`cr_ren` stays 0 in its request cycle), and its mask bit is 0 whatever data is on `cr_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Request to build masks |
| start_ready | output | 1 | High when idle and able to take a request |
| src_code | input | 3 | Condition code for the source mask |
| dst_code | input | 3 | Condition code for the destination mask |
| vl | input | 7 | Vector length, 0 to MAXVL; larger values are clamped to MAXVL |
| done_valid | output | 1 | Masks complete and held |
| done_ready | input | 1 | Consumer takes the masks |
| cr_ren | output | 8 | One-hot field read enable toward the condition-register file |
| cr_rdata | input | 4 | Field data, valid one clock after the enable |
| src_mask | output | 64 | Source predicate mask |
| dst_mask | output | 64 | Destination predicate mask |

## Verification
Two events can fall on the same clock edge: the hand-off of finished masks through `done_ready`, and a new request on `start_valid`. The bench holds `start_valid` high through the whole done phase and raises `done_ready` on the same edge. It then expects the block to be idle, with `done_valid` low and `start_ready` high, and with no new read sequence started. Rising `cr_rdata` is also driven with random values in cycles that carry no request, so that an element with no field, or a capture taken on the wrong cycle, shows up as a wrong mask bit.

// File: rtl/crpm_pkg.sv
package crpm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_CAP  = 2'd2,
    ST_DONE = 2'd3
  } crpm_state_e;

  typedef struct packed {
    logic [1:0] bit_idx;
    logic       invert;
  } crpm_sel_t;

  // condition code -> field bit and inversion
  function automatic crpm_sel_t decode_code(input logic [2:0] code);
    crpm_sel_t s;
    s.bit_idx = code[2:1];
    s.invert  = ~code[0];
    return s;
  endfunction

  function automatic logic pick_bit(input logic [3:0] fld, input crpm_sel_t s);
    return fld[s.bit_idx] ^ s.invert;
  endfunction

endpackage

// File: rtl/crpm_decode.sv
module crpm_decode
  import crpm_pkg::*;
(
  input  logic [2:0] code,
  output crpm_sel_t  sel
);
  assign sel = decode_code(code);
endmodule

// File: rtl/crpm_mask_reg.sv
module crpm_mask_reg #(
  parameter int W  = 64,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_pos,
  input  logic          wr_bit,
  output logic [W-1:0]  mask
);
  always_ff @(posedge clk) begin
    if (!rst_n)     mask <= '0;
    else if (clear) mask <= '0;
    else if (wr_en) mask[wr_pos] <= wr_bit;
  end
endmodule

// File: rtl/crpm_ctrl.sv
module crpm_ctrl
  import crpm_pkg::*;
#(
  parameter int MAXVL     = 64,
  parameter int CR_FIELDS = 8,
  parameter int FIELD_OFS = 0,
  localparam int IW  = $clog2(MAXVL),
  localparam int VLW = $clog2(MAXVL + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_valid,
  output logic                 start_ready,
  input  logic [VLW-1:0]       vl_in,
  output logic                 done_valid,
  input  logic                 done_ready,
  output logic [CR_FIELDS-1:0] cr_ren,
  output logic                 clear_o,
  output logic                 wr_en,
  output logic                 wr_phase,
  output logic [IW-1:0]        wr_pos,
  output logic                 hit_o
);
  localparam logic [VLW-1:0] VL_MAX = VLW'(MAXVL);

  crpm_state_e      state;
  logic [IW-1:0]    elem;
  logic             phase;
  logic [VLW-1:0]   vl_q;
  logic [VLW-1:0]   vl_eff;
  logic             accept;
  logic             is_last;
  int               fidx;

  assign vl_eff  = (vl_in > VL_MAX) ? VL_MAX : vl_in;
  assign accept  = (state == ST_IDLE) && start_valid;
  assign is_last = ({1'b0, elem} == (vl_q - VLW'(1)));
  assign fidx    = CR_FIELDS - 1 - FIELD_OFS - int'(elem);
  assign hit_o   = (fidx >= 0);

  always_comb begin
    for (int f = 0; f < CR_FIELDS; f++)
      cr_ren[f] = (state == ST_REQ) && (f == fidx);
  end

  assign start_ready = (state == ST_IDLE);
  assign done_valid  = (state == ST_DONE);
  assign clear_o     = accept;
  assign wr_en       = (state == ST_CAP);
  assign wr_phase    = phase;
  assign wr_pos      = elem;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      elem  <= '0;
      phase <= 1'b0;
      vl_q  <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start_valid) begin
          vl_q  <= vl_eff;
          elem  <= '0;
          phase <= 1'b0;
          state <= (vl_eff == '0) ? ST_DONE : ST_REQ;
        end
        ST_REQ: state <= ST_CAP;
        ST_CAP: begin
          if (!is_last) begin
            elem  <= elem + IW'(1);
            state <= ST_REQ;
          end else if (!phase) begin
            elem  <= '0;
            phase <= 1'b1;
            state <= ST_REQ;
          end else begin
            state <= ST_DONE;
          end
        end
        ST_DONE: if (done_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_onehot_ren_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cr_ren));

  assert_capture_follows_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cr_ren != '0) |=> (wr_en && cr_ren == '0));

  assert_zero_vl_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready && vl_in == '0) |=> done_valid);

  assert_ready_excl_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_ready && done_valid));

  assert_done_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_ready) |=> done_valid);

endmodule

// File: rtl/crpred_mask_builder.sv
module crpred_mask_builder
  import crpm_pkg::*;
#(
  parameter int MAXVL     = 64,
  parameter int CR_FIELDS = 8,
  parameter int FIELD_OFS = 0,
  localparam int IW  = $clog2(MAXVL),
  localparam int VLW = $clog2(MAXVL + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_valid,
  output logic                 start_ready,
  input  logic [2:0]           src_code,
  input  logic [2:0]           dst_code,
  input  logic [VLW-1:0]       vl,
  output logic                 done_valid,
  input  logic                 done_ready,
  output logic [CR_FIELDS-1:0] cr_ren,
  input  logic [3:0]           cr_rdata,
  output logic [MAXVL-1:0]     src_mask,
  output logic [MAXVL-1:0]     dst_mask
);
  logic          clear;
  logic          wr_en;
  logic          wr_phase;
  logic [IW-1:0] wr_pos;
  logic          hit;
  logic          wr_bit;

  logic [2:0]       code_in [2];
  logic [2:0]       code_q  [2];
  crpm_sel_t        sel     [2];
  logic [MAXVL-1:0] mask    [2];

  assign code_in[0] = src_code;
  assign code_in[1] = dst_code;

  crpm_ctrl #(
    .MAXVL(MAXVL), .CR_FIELDS(CR_FIELDS), .FIELD_OFS(FIELD_OFS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .start_valid(start_valid), .start_ready(start_ready),
    .vl_in(vl),
    .done_valid(done_valid), .done_ready(done_ready),
    .cr_ren(cr_ren),
    .clear_o(clear), .wr_en(wr_en), .wr_phase(wr_phase),
    .wr_pos(wr_pos), .hit_o(hit)
  );

  // out-of-range elements store a cleared bit
  assign wr_bit = hit ? pick_bit(cr_rdata, sel[wr_phase]) : 1'b0;

  for (genvar g = 0; g < 2; g++) begin : g_side
    always_ff @(posedge clk) begin
      if (!rst_n)     code_q[g] <= '0;
      else if (clear) code_q[g] <= code_in[g];
    end

    crpm_decode u_dec (.code(code_q[g]), .sel(sel[g]));

    crpm_mask_reg #(.W(MAXVL), .IW(IW)) u_mask (
      .clk(clk), .rst_n(rst_n), .clear(clear),
      .wr_en(wr_en && (wr_phase == 1'(g))),
      .wr_pos(wr_pos), .wr_bit(wr_bit),
      .mask(mask[g])
    );
  end

  assign src_mask = mask[0];
  assign dst_mask = mask[1];

  assert_masks_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !done_ready) |=> ($stable(src_mask) && $stable(dst_mask)));

  assert_dst_after_src_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_phase) |=> !(wr_en && !wr_phase));

endmodule

// File: tb/test_crpred_mask_builder.sv
module test_crpred_mask_builder;
  localparam int TB_MAXVL = 64;
  localparam int TB_NF    = 8;
  localparam int TB_OFS   = 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [2:0]  src_code = '0;
  logic [2:0]  dst_code = '0;
  logic [6:0]  vl = '0;
  logic        done_valid;
  logic        done_ready = 1'b0;
  logic [7:0]  cr_ren;
  logic [3:0]  cr_rdata = '0;
  logic [63:0] src_mask;
  logic [63:0] dst_mask;

  int checks = 0;
  int failures = 0;
  logic finished = 1'b0;

  logic [3:0] crf [TB_NF];
  int obs [256];
  int nobs = 0;

  always #4 clk = ~clk;

  crpred_mask_builder #(.MAXVL(TB_MAXVL), .CR_FIELDS(TB_NF), .FIELD_OFS(TB_OFS))
    i_crpred_mask_builder (
      .clk(clk), .rst_n(rst_n),
      .start_valid(start_valid), .start_ready(start_ready),
      .src_code(src_code), .dst_code(dst_code), .vl(vl),
      .done_valid(done_valid), .done_ready(done_ready),
      .cr_ren(cr_ren), .cr_rdata(cr_rdata),
      .src_mask(src_mask), .dst_mask(dst_mask));

  // register file model: one clock of read latency, noise when idle
  always @(posedge clk) begin
    logic [3:0] d;
    d = 4'($urandom);
    for (int f = 0; f < TB_NF; f++)
      if (cr_ren == (8'd1 << f)) d = crf[f];
    cr_rdata <= d;
  end

  // request log
  always @(negedge clk) begin
    if (cr_ren != '0 && nobs < 256) begin
      obs[nobs] = -1;
      for (int f = 0; f < TB_NF; f++)
        if (cr_ren == (8'd1 << f)) obs[nobs] = f;
      nobs++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // condition table written out case by case
  function automatic logic [63:0] expect_mask(input logic [2:0] code, input int v);
    int b;
    logic inv;
    logic [63:0] m;
    case (code)
      3'd0: begin b = 0; inv = 1; end
      3'd1: begin b = 0; inv = 0; end
      3'd2: begin b = 1; inv = 1; end
      3'd3: begin b = 1; inv = 0; end
      3'd4: begin b = 2; inv = 1; end
      3'd5: begin b = 2; inv = 0; end
      3'd6: begin b = 3; inv = 1; end
      default: begin b = 3; inv = 0; end
    endcase
    m = '0;
    for (int i = 0; i < v; i++)
      if (i + TB_OFS <= TB_NF - 1) m[i] = crf[TB_NF - 1 - TB_OFS - i][b] ^ inv;
    return m;
  endfunction

  task automatic run(input logic [2:0] sc, input logic [2:0] dc, input int v,
                     input string tag);
    int cnt;
    int k;
    logic [63:0] es, ed, hs, hd;
    for (int f = 0; f < TB_NF; f++) crf[f] = 4'($urandom);
    @(negedge clk);
    src_code = sc; dst_code = dc; vl = 7'(v);
    start_valid = 1'b1;
    nobs = 0;
    check(start_ready == 1'b1, "R8", {tag, " idle ready"}, 64'(start_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    start_valid = 1'b0;
    src_code = 3'($urandom); dst_code = 3'($urandom); vl = 7'($urandom);
    cnt = 0;
    while (!done_valid && cnt < 2000) begin
      @(posedge clk);
      @(negedge clk);
      cnt++;
    end
    check(cnt == 4 * v, "R4", {tag, " cycles to done"}, 64'(cnt), 64'(4 * v));
    es = expect_mask(sc, v);
    ed = expect_mask(dc, v);
    check(src_mask == es, "R2", {tag, " src mask"}, src_mask, es);
    check(dst_mask == ed, "R2", {tag, " dst mask"}, dst_mask, ed);
    if (v < 64) begin
      check((src_mask >> v) == 0 && (dst_mask >> v) == 0, "R6", {tag, " upper bits"},
            src_mask | dst_mask, 64'(0));
    end
    // expected request order: source elements, then destination elements
    k = 0;
    for (int p = 0; p < 2; p++)
      for (int i = 0; i < v; i++)
        if (i + TB_OFS <= TB_NF - 1) begin
          if (k < nobs)
            check(obs[k] == TB_NF - 1 - TB_OFS - i, "R3", {tag, " field order R5"},
                  64'(obs[k]), 64'(TB_NF - 1 - TB_OFS - i));
          k++;
        end
    check(nobs == k, "R10", {tag, " read count"}, 64'(nobs), 64'(k));
    // hold results while consumer is not ready
    hs = src_mask; hd = dst_mask;
    start_valid = 1'b1;
    for (int j = 0; j < 3; j++) begin
      @(posedge clk);
      @(negedge clk);
      check(done_valid && !start_ready && src_mask == hs && dst_mask == hd, "R9",
            {tag, " hold"}, {src_mask[31:0], dst_mask[31:0]}, {hs[31:0], hd[31:0]});
    end
    // release with a start request on the same edge
    done_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    done_ready = 1'b0;
    start_valid = 1'b0;
    check(!done_valid && start_ready, "R8", {tag, " release to idle"},
          {62'd0, done_valid, start_ready}, 64'd1);
    @(posedge clk);
    @(negedge clk);
    check(cr_ren == '0 && start_ready, "R8", {tag, " no hidden start"},
          64'(cr_ren), 64'(0));
  endtask

  initial begin
    void'($urandom(32'h5A17));
    for (int f = 0; f < TB_NF; f++) crf[f] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(start_ready && !done_valid && cr_ren == '0, "R8", "reset idle",
          {61'd0, start_ready, done_valid, |cr_ren}, 64'd4);
    check(src_mask == '0 && dst_mask == '0, "R6", "reset masks",
          src_mask | dst_mask, 64'd0);
    rst_n = 1'b1;
    // R1: every code on both sides
    for (int c = 0; c < 8; c++) run(3'(c), 3'(7 - c), 7, "R1 code sweep");
    // R7: empty loop
    run(3'd4, 3'd5, 0, "R7 vl zero");
    check(nobs == 0, "R7", "no reads at vl zero", 64'(nobs), 64'd0);
    run(3'd2, 3'd6, 1, "R2 single");
    // R10: elements past the last field
    run(3'd1, 3'd0, 12, "R10 beyond fields");
    run(3'd3, 3'd7, 64, "R6 full length");
    for (int n = 0; n < 30; n++)
      run(3'($urandom), 3'($urandom), int'($urandom_range(0, 12)), "random");
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule